// File: doc/BRIEF.md
# PLL lock settling timer

This block decides when a PLL may be treated as settled. Software programs a settling count (in slow-reference-clock cycles), a PLL enable bit and a PLL parameter field through a single configuration write. Any write that turns the PLL on, or that changes the parameter field while the PLL runs, drops the lock flag and restarts the countdown from the programmed count. The countdown advances only on rising edges of the slow reference clock, which is synchronized into the system clock domain. When the countdown expires the lock flag rises and stays up.

The lock flag drives an interrupt request through a mask bit. The mask has a set-pulse input and a clear-pulse input. A second path produces the PLL output clock, either passed straight through or halved by a toggle flop that is held in reset while the PLL is off.

Top module: `pll_lock_timer`

## Requirements
- R1: After reset, lock_o, irq_o and int_mask_o are 0.
- R2: A configuration write with cfg_en_i=1 while the PLL is off clears lock_o on the same clock edge and loads cfg_count_i into the countdown.
- R3: The countdown moves only on synchronized rising edges of slow_clk_i, never on clk_i alone; with a loaded count N of 1 or more, lock_o stays 0 after N-1 slow rising edges and is 1 after the N-th.
- R4: A loaded count of 0 sets lock_o after the first slow rising edge following the load.
- R5: While enabled, a configuration write with a different cfg_param_i clears lock_o and restarts the countdown from cfg_count_i; a write with an identical cfg_param_i and cfg_en_i=1 leaves lock_o and the countdown unchanged.
- R6: A configuration write with cfg_en_i=0 clears lock_o, and lock_o remains 0 through any number of slow rising edges until the PLL is enabled again.
- R7: irq_o is lock_o AND int_mask_o; a pulse on int_en_set_i sets the mask, a pulse on int_en_clr_i clears it, and clear wins when both pulse in the same cycle.
- R8: With the PLL enabled, div2_sel_i=0 passes pll_clk_i to pll_clk_o; div2_sel_i=1 gives one rising edge of pll_clk_o per two rising edges of pll_clk_i.
- R9: With the PLL disabled and div2_sel_i=1, pll_clk_o stays low.
- R10: Once set, lock_o stays 1 through further slow rising edges; the countdown does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | PLL enable value written |
| cfg_param_i | input | PARAM_W | PLL parameter field written |
| cfg_count_i | input | CNT_W | Settling count in slow-clock cycles |
| int_en_set_i | input | 1 | Pulse: set interrupt mask |
| int_en_clr_i | input | 1 | Pulse: clear interrupt mask |
| div2_sel_i | input | 1 | Select halved PLL output clock |
| pll_clk_i | input | 1 | PLL output clock |
| lock_o | output | 1 | PLL settled flag |
| irq_o | output | 1 | Masked lock interrupt request |
| int_mask_o | output | 1 | Current interrupt mask |
| pll_clk_o | output | 1 | PLL clock, direct or halved |

## Verification
The countdown is driven with counts of 3, 2 and 0, and with long idle stretches of system clock and no slow edges, which separates a counter ticking on the slow edge from one ticking on clk_i and exposes an off-by-one at the expiry edge. Rewrites with an identical parameter, a changed parameter and a disable are applied against an already locked flag, telling a restart from a harmless rewrite and from a stop. The mask is exercised by separate set and clear pulses and by both at once, and the clock path is measured by counting output edges in a fixed window in direct mode, halved mode and disabled state.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  parameter int unsigned CNT_W_DEF   = 16;
  parameter int unsigned PARAM_W_DEF = 8;
  parameter int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCKED = 2'd2
  } lock_state_e;
endpackage

// File: rtl/slow_edge_sync.sv
module slow_edge_sync #(
  parameter int unsigned STAGES = pll_lock_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  output logic tick_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[LEN-2:0], slow_clk_i};
  end

  // rising edge seen at the last synchronized stage
  assign tick_o = sync_q[LEN-2] & ~sync_q[LEN-1];

  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/settle_counter.sv
module settle_counter
  import pll_lock_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned PARAM_W = PARAM_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               cfg_we_i,
  input  logic               cfg_en_i,
  input  logic [PARAM_W-1:0] cfg_param_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  output logic               en_o,
  output logic               lock_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  lock_state_e        state_q;
  logic               en_q;
  logic [PARAM_W-1:0] param_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               restart;
  logic               stop;
  logic               expire;

  assign stop    = cfg_we_i & ~cfg_en_i;
  assign restart = cfg_we_i & cfg_en_i & (~en_q | (cfg_param_i != param_q));
  assign expire  = (state_q == ST_SETTLE) & tick_i & (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      param_q <= '0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      param_q <= cfg_param_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (stop) begin
      state_q <= ST_OFF;
    end else if (restart) begin
      state_q <= ST_SETTLE;
      cnt_q   <= cfg_count_i;
    end else if (expire) begin
      state_q <= ST_LOCKED;
      cnt_q   <= '0;
    end else if (state_q == ST_SETTLE && tick_i) begin
      cnt_q   <= cnt_q - ONE;
    end
  end

  assign en_o   = en_q;
  assign lock_o = (state_q == ST_LOCKED);

  a_r2_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !lock_o);
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cfg_we_i) |=> $stable(cnt_q));
  a_r6_off_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !lock_o);
  a_r10_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !cfg_we_i) |=> lock_o);
endmodule

// File: rtl/lock_irq_mask.sv
module lock_irq_mask (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic set_i,
  input  logic clr_i,
  output logic mask_o,
  output logic irq_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= 1'b0;
    else if (clr_i) mask_q <= 1'b0;
    else if (set_i) mask_q <= 1'b1;
  end

  assign mask_o = mask_q;
  assign irq_o  = lock_i & mask_q;

  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> mask_o);
  a_r7_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !mask_o);
endmodule

// File: rtl/pll_clk_div2.sv
module pll_clk_div2 (
  input  logic pll_clk_i,
  input  logic run_ni,
  input  logic sel_i,
  output logic clk_o
);
  logic half_q;

  // held at a known phase while the PLL is off
  always_ff @(posedge pll_clk_i or negedge run_ni) begin
    if (!run_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign clk_o = sel_i ? half_q : pll_clk_i;
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_lock_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned PARAM_W = PARAM_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slow_clk_i,
  input  logic               cfg_we_i,
  input  logic               cfg_en_i,
  input  logic [PARAM_W-1:0] cfg_param_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  input  logic               int_en_set_i,
  input  logic               int_en_clr_i,
  input  logic               div2_sel_i,
  input  logic               pll_clk_i,
  output logic               lock_o,
  output logic               irq_o,
  output logic               int_mask_o,
  output logic               pll_clk_o
);
  logic tick;
  logic pll_en;
  logic lock;
  logic div_run_n;

  slow_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_clk_i (slow_clk_i),
    .tick_o     (tick)
  );

  settle_counter #(.CNT_W(CNT_W), .PARAM_W(PARAM_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cfg_we_i    (cfg_we_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_param_i (cfg_param_i),
    .cfg_count_i (cfg_count_i),
    .en_o        (pll_en),
    .lock_o      (lock)
  );

  lock_irq_mask u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock),
    .set_i  (int_en_set_i),
    .clr_i  (int_en_clr_i),
    .mask_o (int_mask_o),
    .irq_o  (irq_o)
  );

  assign div_run_n = rst_ni & pll_en;

  pll_clk_div2 u_div (
    .pll_clk_i (pll_clk_i),
    .run_ni    (div_run_n),
    .sel_i     (div2_sel_i),
    .clk_o     (pll_clk_o)
  );

  assign lock_o = lock;

  a_r7_irq_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lock_o && int_mask_o));
endmodule

// File: tb/pll_lock_timer_test.sv
`timescale 1ns/100ps
module pll_lock_timer_test;
  localparam int CW = 16;
  localparam int PW = 8;

  typedef struct {
    string req;
    int    kind;   // 0 lock, 1 irq, 2 mask, 3 window edge count
    int    exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow = 1'b0;
  logic          we = 1'b0;
  logic          en = 1'b0;
  logic [PW-1:0] param = '0;
  logic [CW-1:0] count = '0;
  logic          mset = 1'b0;
  logic          mclr = 1'b0;
  logic          sel = 1'b0;
  logic          pll_clk = 1'b0;
  logic          lock, irq, mask, pll_out;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  bit counting = 1'b0;
  bit done = 1'b0;

  pll_lock_timer #(.CNT_W(CW), .PARAM_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow),
    .cfg_we_i(we), .cfg_en_i(en), .cfg_param_i(param), .cfg_count_i(count),
    .int_en_set_i(mset), .int_en_clr_i(mclr), .div2_sel_i(sel),
    .pll_clk_i(pll_clk), .lock_o(lock), .irq_o(irq), .int_mask_o(mask),
    .pll_clk_o(pll_out)
  );

  always #2 clk = ~clk;
  always #3.5 pll_clk = ~pll_clk;

  always @(posedge pll_out) if (counting) edges++;

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(lock);
        1: act = int'(irq);
        2: act = int'(mask);
        default: act = edges;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input string req, input int kind, input int exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic e, input logic [PW-1:0] p, input logic [CW-1:0] c);
    @(posedge clk); #1;
    we = 1'b1; en = e; param = p; count = c;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic slow_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 slow = 1'b1;
      repeat (4) @(posedge clk);
      #1 slow = 1'b0;
      repeat (4) @(posedge clk);
      #1;
    end
  endtask

  task automatic mask_pulse(input logic s, input logic c);
    @(posedge clk); #1;
    mset = s; mclr = c;
    @(posedge clk); #1;
    mset = 1'b0; mclr = 1'b0;
  endtask

  task automatic edge_window(input string req, input int exp);
    @(posedge clk); #1;
    edges = 0; counting = 1'b1;
    #98;
    counting = 1'b0;
    expect_item(req, 3, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    expect_item("R1", 0, 0);
    expect_item("R1", 1, 0);
    expect_item("R1", 2, 0);

    // R2/R3 count 3
    wr_cfg(1'b1, 8'd5, 16'd3);
    expect_item("R2", 0, 0);
    repeat (40) @(posedge clk);
    #1 expect_item("R3", 0, 0);      // no slow edges: no progress
    slow_pulse(2);
    expect_item("R3", 0, 0);
    slow_pulse(1);
    expect_item("R3", 0, 1);
    slow_pulse(3);
    expect_item("R10", 0, 1);

    // R7 mask
    expect_item("R7", 1, 0);
    mask_pulse(1'b1, 1'b0);
    expect_item("R7", 2, 1);
    expect_item("R7", 1, 1);
    mask_pulse(1'b1, 1'b1);
    expect_item("R7", 2, 0);
    expect_item("R7", 1, 0);
    mask_pulse(1'b1, 1'b0);

    // R5 identical rewrite keeps lock
    wr_cfg(1'b1, 8'd5, 16'd2);
    expect_item("R5", 0, 1);
    slow_pulse(1);
    expect_item("R5", 0, 1);
    // R5 changed parameter restarts
    wr_cfg(1'b1, 8'd6, 16'd2);
    expect_item("R5", 0, 0);
    expect_item("R5", 1, 0);
    slow_pulse(1);
    expect_item("R5", 0, 0);
    slow_pulse(1);
    expect_item("R5", 0, 1);
    expect_item("R7", 1, 1);

    // R4 zero count
    wr_cfg(1'b1, 8'd7, 16'd0);
    expect_item("R4", 0, 0);
    repeat (20) @(posedge clk);
    #1 expect_item("R4", 0, 0);
    slow_pulse(1);
    expect_item("R4", 0, 1);

    // R8 direct pass while enabled
    sel = 1'b0;
    edge_window("R8", 14);
    sel = 1'b1;
    edge_window("R8", 7);

    // R6 disable
    wr_cfg(1'b0, 8'd7, 16'd0);
    expect_item("R6", 0, 0);
    expect_item("R6", 1, 0);
    slow_pulse(3);
    expect_item("R6", 0, 0);
    // R9 halved output stuck low while off
    edge_window("R9", 0);
    expect_item("R9", 2, 1);

    // re-enable after disable restarts (R2)
    wr_cfg(1'b1, 8'd7, 16'd1);
    expect_item("R2", 0, 0);
    slow_pulse(1);
    expect_item("R2", 0, 1);
    sel = 1'b1;
    edge_window("R8", 7);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule